// File: doc/BRIEF.md
# Big-Endian Load Alignment Unit

This block sits on the return path of a word-wide data memory read. It gets the aligned memory word, the two low bits of the effective address, a load-kind code and the current contents of the destination register. From these it forms the value written back to the destination register. Its output depends only on its present inputs; it holds no state.

Five plain load kinds pick one byte or one halfword from the word and widen it, or pass the whole word through. Two partial-word kinds support unaligned word access in two steps. The "left" kind moves the memory word up by the byte offset and keeps the low bytes of the old register. The "right" kind moves the word down and keeps the high bytes of the old register. Running both on the two ends of an unaligned word builds that word in the register. Byte lanes are big-endian: offset 0 names the most significant byte. Effective-address arithmetic, the memory access itself and faults on misaligned halfword or word addresses are handled outside this block.

Top module: `load_align_unit`

## Requirements
- R1: With kind code 3'b000 (signed byte), the result is the byte in bits [31-8k -: 8] of the memory word for offset k, sign-extended to 32 bits.
- R2: With kind code 3'b001 (unsigned byte), the result is the same byte as in R1, zero-extended.
- R3: With kind code 3'b010 (signed halfword), offset bit 1 picks the halfword: 0 picks bits [31:16] and 1 picks bits [15:0]. The result is that halfword sign-extended, and offset bit 0 has no effect.
- R4: With kind code 3'b011 (unsigned halfword), the result is the halfword chosen as in R3, zero-extended.
- R5: With kind code 3'b100 (word), the result is the memory word unchanged for every offset.
- R6: With kind code 3'b101 (left partial), offset k gives (mem << 8k) | (old & low k bytes). At offset 0 the whole memory word replaces the register.
- R7: With kind code 3'b110 (right partial), offset k gives (mem >> 8(3-k)) | (old & upper 3-k bytes). At offset 3 the whole memory word replaces the register.
- R8: Kind code 3'b111 is unused, and the result equals the old destination value.
- R9: The old destination value has no effect on the result for kind codes 3'b000 through 3'b100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mem_word | input | 32 | Aligned word returned by the data memory |
| addr_lo | input | 2 | Low bits of the effective address (byte offset) |
| load_kind | input | 3 | Load-kind code (see requirements) |
| rd_old | input | 32 | Current value of the destination register |
| rd_new | output | 32 | Value to write back to the destination register |

## Verification
The assertions check the fixed points of the merge loads on every input change. These are full replacement at the end offsets, the old byte kept at the far end of the other offsets, and a plain word load copying the memory word. They also check the width of the widened byte and halfword results and the pass-through on the unused code. The exact byte shuffle at each middle offset, the choice of sign bit, and the fact that the old register value has no effect on the plain loads show only in the bench. The bench compares every kind at every offset against a shift-and-mask model, with both directed and random words.

// File: rtl/lau_pkg.sv
package lau_pkg;

   typedef enum logic [2:0] {
      LK_BYTE_S  = 3'd0,
      LK_BYTE_U  = 3'd1,
      LK_HALF_S  = 3'd2,
      LK_HALF_U  = 3'd3,
      LK_WORD    = 3'd4,
      LK_LEFT    = 3'd5,
      LK_RIGHT   = 3'd6,
      LK_NONE    = 3'd7
   } load_kind_e;

endpackage

// File: rtl/lau_subword_extract.sv
module lau_subword_extract #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic [BYTE_W*LANES-1:0]     word_i,
   input  logic [$clog2(LANES)-1:0]    off_i,
   input  logic                        is_half_i,
   input  logic                        is_signed_i,
   output logic [BYTE_W*LANES-1:0]     ext_o
);
   localparam int DATA_W = BYTE_W * LANES;
   localparam int OFF_W  = $clog2(LANES);
   localparam int HALF_W = 2 * BYTE_W;
   localparam int HALVES = LANES / 2;
   localparam int HOFF_W = OFF_W - 1;

   logic [BYTE_W-1:0] lane_arr [LANES];
   logic [HALF_W-1:0] half_arr [HALVES];
   logic [OFF_W-1:0]  byte_idx;
   logic [HOFF_W-1:0] half_idx;
   logic [BYTE_W-1:0] byte_sel;
   logic [HALF_W-1:0] half_sel;
   logic              sgn;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign lane_arr[j] = word_i[j*BYTE_W +: BYTE_W];
   end
   for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign half_arr[h] = word_i[h*HALF_W +: HALF_W];
   end

   // big-endian: offset 0 names the most significant lane
   assign byte_idx = OFF_W'(LANES - 1) - off_i;
   assign half_idx = HOFF_W'(HALVES - 1) - off_i[OFF_W-1:1];
   assign byte_sel = lane_arr[byte_idx];
   assign half_sel = half_arr[half_idx];

   always_comb begin
      if (is_half_i) begin
         sgn   = is_signed_i & half_sel[HALF_W-1];
         ext_o = {{(DATA_W-HALF_W){sgn}}, half_sel};
      end else begin
         sgn   = is_signed_i & byte_sel[BYTE_W-1];
         ext_o = {{(DATA_W-BYTE_W){sgn}}, byte_sel};
      end
   end

   always_comb begin
      if (!is_half_i && !is_signed_i)
         assert_ubyte_upper_zero_R2: assert (ext_o[DATA_W-1:BYTE_W] == '0)
            else $error("unsigned byte has nonzero upper bits");
      if (is_half_i && !is_signed_i)
         assert_uhalf_upper_zero_R4: assert (ext_o[DATA_W-1:HALF_W] == '0)
            else $error("unsigned halfword has nonzero upper bits");
      if (!is_half_i && is_signed_i)
         assert_sbyte_upper_uniform_R1: assert (ext_o[DATA_W-1:BYTE_W-1] == '0 ||
                                                &ext_o[DATA_W-1:BYTE_W-1])
            else $error("signed byte upper bits not uniform");
      if (is_half_i && is_signed_i)
         assert_shalf_upper_uniform_R3: assert (ext_o[DATA_W-1:HALF_W-1] == '0 ||
                                                &ext_o[DATA_W-1:HALF_W-1])
            else $error("signed halfword upper bits not uniform");
   end

endmodule

// File: rtl/lau_partial_merge.sv
module lau_partial_merge #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic [BYTE_W*LANES-1:0]     word_i,
   input  logic [BYTE_W*LANES-1:0]     old_i,
   input  logic [$clog2(LANES)-1:0]    off_i,
   input  logic                        dir_right_i,
   output logic [BYTE_W*LANES-1:0]     merged_o
);
   localparam int OFF_W = $clog2(LANES);

   logic [BYTE_W-1:0] mem_lane [LANES];

   for (genvar j = 0; j < LANES; j++) begin : g_src
      assign mem_lane[j] = word_i[j*BYTE_W +: BYTE_W];
   end

   for (genvar j = 0; j < LANES; j++) begin : g_dst
      logic [OFF_W-1:0] src_l;
      logic [OFF_W-1:0] src_r;
      logic             take_l;
      logic             take_r;

      // left: lane j receives memory lane j-off when j >= off
      assign src_l  = OFF_W'(j) - off_i;
      assign take_l = (OFF_W'(j) >= off_i);
      // right: lane j receives memory lane j+(LANES-1-off) when j <= off
      assign src_r  = OFF_W'(j) + (OFF_W'(LANES - 1) - off_i);
      assign take_r = (OFF_W'(j) <= off_i);

      always_comb begin
         if (dir_right_i)
            merged_o[j*BYTE_W +: BYTE_W] = take_r ? mem_lane[src_r] : old_i[j*BYTE_W +: BYTE_W];
         else
            merged_o[j*BYTE_W +: BYTE_W] = take_l ? mem_lane[src_l] : old_i[j*BYTE_W +: BYTE_W];
      end
   end

endmodule

// File: rtl/load_align_unit.sv
module load_align_unit
   import lau_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   localparam int DATA_W = BYTE_W * LANES,
   localparam int OFF_W  = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] mem_word,
   input  logic [OFF_W-1:0]  addr_lo,
   input  logic [2:0]        load_kind,
   input  logic [DATA_W-1:0] rd_old,
   output logic [DATA_W-1:0] rd_new
);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("BYTE_W must be at least 2");
   end
   if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two, at least 4");
   end

   load_kind_e        kind;
   logic [DATA_W-1:0] ext_val;
   logic [DATA_W-1:0] merge_val;
   logic              is_half;
   logic              is_signed;

   assign kind      = load_kind_e'(load_kind);
   assign is_half   = (kind == LK_HALF_S) || (kind == LK_HALF_U);
   assign is_signed = (kind == LK_BYTE_S) || (kind == LK_HALF_S);

   lau_subword_extract #(.BYTE_W(BYTE_W), .LANES(LANES)) u_extract (
      .word_i      (mem_word),
      .off_i       (addr_lo),
      .is_half_i   (is_half),
      .is_signed_i (is_signed),
      .ext_o       (ext_val)
   );

   lau_partial_merge #(.BYTE_W(BYTE_W), .LANES(LANES)) u_merge (
      .word_i      (mem_word),
      .old_i       (rd_old),
      .off_i       (addr_lo),
      .dir_right_i (kind == LK_RIGHT),
      .merged_o    (merge_val)
   );

   always_comb begin
      unique case (kind)
         LK_BYTE_S, LK_BYTE_U,
         LK_HALF_S, LK_HALF_U: rd_new = ext_val;
         LK_WORD:              rd_new = mem_word;
         LK_LEFT, LK_RIGHT:    rd_new = merge_val;
         default:              rd_new = rd_old;
      endcase
   end

   always_comb begin
      if (kind == LK_WORD)
         assert_word_copy_R5: assert (rd_new == mem_word)
            else $error("word load altered the memory word");
      if (kind == LK_NONE)
         assert_unused_keeps_old_R8: assert (rd_new == rd_old)
            else $error("unused code changed the destination");
      if (kind == LK_LEFT && addr_lo == '0)
         assert_left_full_R6: assert (rd_new == mem_word)
            else $error("left partial at offset 0 not a full replace");
      if (kind == LK_LEFT && addr_lo != '0)
         assert_left_keeps_low_R6: assert (rd_new[BYTE_W-1:0] == rd_old[BYTE_W-1:0])
            else $error("left partial lost the lowest old byte");
      if (kind == LK_RIGHT && addr_lo == OFF_W'(LANES - 1))
         assert_right_full_R7: assert (rd_new == mem_word)
            else $error("right partial at last offset not a full replace");
      if (kind == LK_RIGHT && addr_lo != OFF_W'(LANES - 1))
         assert_right_keeps_high_R7: assert (rd_new[DATA_W-1 -: BYTE_W] == rd_old[DATA_W-1 -: BYTE_W])
            else $error("right partial lost the highest old byte");
   end

endmodule

// File: tb/load_align_unit_bench.sv
module load_align_unit_bench;

   logic        clk = 1'b0;
   logic [31:0] mem_word;
   logic [1:0]  addr_lo;
   logic [2:0]  load_kind;
   logic [31:0] rd_old;
   logic [31:0] rd_new;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   load_align_unit u_load_align_unit (
      .mem_word  (mem_word),
      .addr_lo   (addr_lo),
      .load_kind (load_kind),
      .rd_old    (rd_old),
      .rd_new    (rd_new)
   );

   function automatic logic [31:0] model(logic [2:0] k, logic [1:0] a,
                                         logic [31:0] w, logic [31:0] o);
      logic [31:0] b;
      logic [31:0] h;
      b = (w >> (8 * (3 - a))) & 32'hFF;
      h = a[1] ? (w & 32'hFFFF) : (w >> 16);
      case (k)
         3'd0: return {{24{b[7]}}, b[7:0]};
         3'd1: return b;
         3'd2: return {{16{h[15]}}, h[15:0]};
         3'd3: return h;
         3'd4: return w;
         3'd5: return (a == 2'd0) ? w :
                      ((w << (8 * a)) | (o & ((32'd1 << (8 * a)) - 32'd1)));
         3'd6: return (a == 2'd3) ? w :
                      ((w >> (8 * (3 - a))) | (o & ~(32'hFFFFFFFF >> (8 * (3 - a)))));
         default: return o;
      endcase
   endfunction

   function automatic string tag_of(logic [2:0] k);
      case (k)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R6";
         3'd6: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h (kind %0d off %0d mem %08h old %08h)",
                  tag, act, exp, load_kind, addr_lo, mem_word, rd_old);
      end
   endtask

   task automatic apply(logic [2:0] k, logic [1:0] a, logic [31:0] w, logic [31:0] o);
      @(negedge clk);
      load_kind = k; addr_lo = a; mem_word = w; rd_old = o;
      #1;
      check_eq(tag_of(k), rd_new, model(k, a, w, o));
   endtask

   initial begin
      #800000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r9_first;
      mem_word = '0; addr_lo = '0; load_kind = 3'd7; rd_old = 32'h0BADF00D;
      #1;
      check_eq("R8", rd_new, 32'h0BADF00D);

      // every kind at every offset with lanes of mixed sign
      for (int k = 0; k < 8; k++)
         for (int a = 0; a < 4; a++)
            apply(3'(k), 2'(a), 32'h80F17F02, 32'hA1B2C3D4);

      // directed merge shapes
      @(negedge clk);
      load_kind = 3'd5; addr_lo = 2'd1; mem_word = 32'h11223344; rd_old = 32'hAABBCCDD; #1;
      check_eq("R6", rd_new, 32'h223344DD);
      @(negedge clk);
      addr_lo = 2'd3; #1;
      check_eq("R6", rd_new, 32'h44BBCCDD);
      @(negedge clk);
      load_kind = 3'd6; addr_lo = 2'd0; #1;
      check_eq("R7", rd_new, 32'hAABBCC11);
      @(negedge clk);
      addr_lo = 2'd2; #1;
      check_eq("R7", rd_new, 32'hAA112233);
      @(negedge clk);
      addr_lo = 2'd3; #1;
      check_eq("R7", rd_new, 32'h11223344);

      // R3: offset bit 0 has no effect on halfword selection
      @(negedge clk);
      load_kind = 3'd2; mem_word = 32'h12348765; addr_lo = 2'd3; #1;
      check_eq("R3", rd_new, 32'hFFFF8765);
      @(negedge clk);
      addr_lo = 2'd1; #1;
      check_eq("R3", rd_new, 32'h00001234);

      // R9: old value cannot reach the result of plain loads
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         load_kind = 3'(k); addr_lo = 2'd2; mem_word = 32'h5A6B7C8D; rd_old = 32'h00000000; #1;
         r9_first = rd_new;
         @(negedge clk);
         rd_old = 32'hFFFFFFFF; #1;
         check_eq("R9", rd_new, r9_first);
      end

      void'($urandom(32'd20240611));
      for (int n = 0; n < 3000; n++)
         apply(3'($urandom_range(7, 0)), 2'($urandom_range(3, 0)), $urandom, $urandom);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule